// File: doc/BRIEF.md
# Single-Channel Block Transfer Controller

This block moves a block of words between one I/O device and memory so that the processor does not have to copy each word itself. Before a transfer, the processor writes three registers through a simple write port. These registers are the first memory address, the number of words, and a control word. The control word sets the direction, the mode and the start bit. Once the block has been started, the device asks for service by raising its request line. The controller then asks for the system bus and does nothing on the bus until the bus is granted. For each word it runs a two-cycle memory access and gives the device a one-cycle acknowledge.

There are two modes. In cycle-stealing mode the controller gives the bus back after every word, so the processor can use the bus between words. In burst mode the controller keeps the bus until the whole block has moved. When the last word has moved, the controller releases the bus and raises an interrupt. The interrupt stays high until the processor clears it.

Top module: `xfer_dma`

## Requirements
- R1: While reset is asserted and after it is released, `bus_req`, `mem_rd`, `mem_wr`, `dev_ack` and `irq` are low.
- R2: Register select 0 loads the start address and select 1 loads the word count (low CW bits). Select 2 loads the control word, whose bits are:
  - bit 0: start.
  - bit 1: direction. 1 means memory to device, and each word uses `mem_rd`. 0 means device to memory, and each word uses `mem_wr`.
  - bit 2: mode. 1 means burst and 0 means cycle stealing.
  - bit 3: interrupt clear, written as 1 to clear.
- R3: A started block raises `bus_req` only after `dev_req` has been seen high. No memory strobe rises unless `bus_grant` was high in the previous cycle.
- R4: Each word holds its memory strobe for exactly two cycles. `dev_ack` pulses high for one cycle, in the second of those cycles. In that cycle `dev_rdata` carries `mem_rdata` and `mem_wdata` carries `dev_wdata`.
- R5: The first word uses the programmed address. Each following word uses the next address up. Exactly the programmed count of words moves.
- R6: In cycle-stealing mode `bus_req` drops after every word. While `dev_req` is low, no new word starts and `bus_req` stays low.
- R7: In burst mode `bus_req` stays high from the first word to the last. While the grant holds, the words follow each other back to back.
- R8: If `bus_grant` falls during a word, that word still completes. In burst mode the controller then keeps `bus_req` high and issues no strobe until the grant returns.
- R9: In the cycle after the last `dev_ack`, `bus_req` is low and `irq` is high. `irq` stays high until a control write with bit 3 set is made while the controller is idle.
- R10: Register writes made while a block is in progress are ignored.
- R11: Starting with a word count of zero raises `irq` at once and requests no bus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select: 0 address, 1 count, 2 control |
| reg_wdata | input | AW | Register write data |
| dev_req | input | 1 | Device service request |
| dev_ack | output | 1 | One-cycle word acknowledge to the device |
| dev_wdata | input | DW | Word from the device (device to memory) |
| dev_rdata | output | DW | Word to the device (memory to device) |
| bus_req | output | 1 | System bus request |
| bus_grant | input | 1 | System bus grant |
| mem_addr | output | AW | Memory address |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| mem_wdata | output | DW | Memory write data |
| mem_rdata | input | DW | Memory read data |
| irq | output | 1 | Block-complete interrupt |

## Verification
The bench builds the block with AW=12, DW=8 and CW=4. The 4-bit count makes the largest block (15 words) short enough to run in full, so both a 15-word burst and single-word blocks in each mode are covered. The 12-bit address lets blocks start at scattered locations, with each word checked against a memory whose contents are derived from the address. Grant withdrawal in the middle of a word, pauses in the device request, writes made during an active block and a zero-count start are all reached within a few dozen cycles each.

// File: rtl/xfer_dma.sv
module xfer_dma #(
  parameter int AW = 16,
  parameter int DW = 8,
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic [1:0]    reg_sel,
  input  logic [AW-1:0] reg_wdata,
  input  logic          dev_req,
  output logic          dev_ack,
  input  logic [DW-1:0] dev_wdata,
  output logic [DW-1:0] dev_rdata,
  output logic          bus_req,
  input  logic          bus_grant,
  output logic [AW-1:0] mem_addr,
  output logic          mem_rd,
  output logic          mem_wr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  output logic          irq
);

  localparam logic [1:0] SEL_ADDR = 2'd0;
  localparam logic [1:0] SEL_CNT  = 2'd1;
  localparam logic [1:0] SEL_CTL  = 2'd2;
  localparam int CB_START = 0;
  localparam int CB_DIR   = 1;
  localparam int CB_BURST = 2;
  localparam int CB_CLR   = 3;

  typedef enum logic [1:0] {S_IDLE, S_ARB, S_ACC1, S_ACC2} st_t;

  st_t           st_q;
  logic [AW-1:0] addr_q;
  logic [CW-1:0] cnt_q;
  logic          dir_q, burst_q, busy_q, irq_q;

  wire idle_wr  = reg_wr && !busy_q;
  wire last_w   = (cnt_q == CW'(1));
  wire in_acc   = (st_q == S_ACC1) || (st_q == S_ACC2);
  wire cnt_zero = (cnt_q == '0);

  assign bus_req   = (st_q != S_IDLE);
  assign mem_addr  = addr_q;
  assign mem_rd    = in_acc && dir_q;
  assign mem_wr    = in_acc && !dir_q;
  assign mem_wdata = dev_wdata;
  assign dev_rdata = mem_rdata;
  assign dev_ack   = (st_q == S_ACC2);
  assign irq       = irq_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= S_IDLE;
      addr_q  <= '0;
      cnt_q   <= '0;
      dir_q   <= 1'b0;
      burst_q <= 1'b0;
      busy_q  <= 1'b0;
      irq_q   <= 1'b0;
    end else begin
      if (idle_wr) begin
        case (reg_sel)
          SEL_ADDR: addr_q <= reg_wdata;
          SEL_CNT:  cnt_q  <= reg_wdata[CW-1:0];
          SEL_CTL: begin
            dir_q   <= reg_wdata[CB_DIR];
            burst_q <= reg_wdata[CB_BURST];
            if (reg_wdata[CB_START] && !cnt_zero) busy_q <= 1'b1;
            if (reg_wdata[CB_START] && cnt_zero) irq_q <= 1'b1;
            else if (reg_wdata[CB_CLR]) irq_q <= 1'b0;
          end
          default: ;
        endcase
      end
      case (st_q)
        S_IDLE: if (busy_q && dev_req) st_q <= S_ARB;
        S_ARB:  if (bus_grant) st_q <= S_ACC1;
        S_ACC1: st_q <= S_ACC2;
        S_ACC2: begin
          addr_q <= addr_q + AW'(1);
          cnt_q  <= cnt_q - CW'(1);
          if (last_w) begin
            st_q   <= S_IDLE;
            busy_q <= 1'b0;
            irq_q  <= 1'b1;
          end else if (!burst_q) st_q <= S_IDLE;
          else if (bus_grant)    st_q <= S_ACC1;
          else                   st_q <= S_ARB;
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end

  p_grant_first_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_rd || mem_wr) |-> $past(bus_grant));

  p_strobe_two_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_rd || mem_wr) |=> (mem_rd || mem_wr) && dev_ack);

  p_ack_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    dev_ack |=> !dev_ack);

  p_addr_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    dev_ack |=> (mem_addr == $past(mem_addr) + AW'(1)));

  p_steal_gap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (dev_ack && !burst_q) |=> !bus_req);

  p_burst_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (dev_ack && burst_q && !last_w) |=> bus_req);

  p_done_free_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> !bus_req);

  p_irq_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !(idle_wr && reg_sel == SEL_CTL && reg_wdata[CB_CLR])) |=> irq);

endmodule

// File: tb/xfer_dma_tb.sv
`timescale 1ns/1ps
module xfer_dma_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_wr = 1'b0;
  logic [1:0] reg_sel = 2'd0;
  logic [11:0] reg_wdata = '0;
  logic dev_req = 1'b1, grant_en = 1'b1;
  logic [7:0] dev_wdata = 8'h30;
  logic dev_ack, bus_req, mem_rd, mem_wr, irq, bus_grant;
  logic [7:0] dev_rdata, mem_wdata, mem_rdata;
  logic [11:0] mem_addr;
  int n_tests = 0, n_fail = 0;
  bit finished = 0;

  always #10 clk = ~clk;
  assign bus_grant = grant_en;
  assign mem_rdata = mem_addr[7:0] ^ 8'hA5;

  xfer_dma #(.AW(12), .DW(8), .CW(4)) u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
    .dev_req(dev_req), .dev_ack(dev_ack), .dev_wdata(dev_wdata), .dev_rdata(dev_rdata),
    .bus_req(bus_req), .bus_grant(bus_grant), .mem_addr(mem_addr), .mem_rd(mem_rd),
    .mem_wr(mem_wr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .irq(irq));

  // {dir, burst, start address, count}
  localparam logic [17:0] VEC [6] = '{
    {1'b0, 1'b0, 12'h010, 4'd3},
    {1'b1, 1'b0, 12'h0F0, 4'd2},
    {1'b0, 1'b1, 12'h400, 4'd5},
    {1'b1, 1'b1, 12'h7F0, 4'd15},
    {1'b1, 1'b0, 12'hABC, 4'd1},
    {1'b0, 1'b1, 12'h123, 4'd1}
  };

  task automatic tick; @(posedge clk); @(negedge clk); endtask

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wreg(input logic [1:0] sel, input logic [11:0] d);
    reg_wr = 1'b1; reg_sel = sel; reg_wdata = d;
    tick;
    reg_wr = 1'b0;
  endtask

  task automatic start(input bit dir, input bit burst, input logic [11:0] a, input logic [3:0] n);
    wreg(2'd0, a);
    wreg(2'd1, {8'h00, n});
    wreg(2'd2, {8'h00, 1'b1, burst, dir, 1'b1});
    dev_wdata = 8'h30;
  endtask

  task automatic watch(input logic [11:0] a0, input int n, input bit dir, input bit burst);
    int words = 0, strobes = 0, falls = 0, cyc = 0;
    bit prev_req = 0, prev_ack = 0, done = 0;
    check(irq == 1'b0, "R9 irq cleared at start", int'(irq), 0);
    while (!done && cyc < 2000) begin
      if (mem_rd || mem_wr) strobes++;
      if (dev_ack) begin
        check(mem_addr == a0 + 12'(words), "R5 word address", int'(mem_addr), int'(a0 + 12'(words)));
        check(mem_rd == dir && mem_wr == !dir, "R2 direction strobe", int'({mem_rd, mem_wr}), int'({dir, !dir}));
        if (dir) check(dev_rdata == ((a0[7:0] + 8'(words)) ^ 8'hA5), "R4 read data",
                       int'(dev_rdata), int'((a0[7:0] + 8'(words)) ^ 8'hA5));
        else     check(mem_wdata == 8'h30 + 8'(words), "R4 write data", int'(mem_wdata), int'(8'h30 + 8'(words)));
        words++;
        dev_wdata = 8'h30 + 8'(words);
      end
      if (prev_req && !bus_req) falls++;
      if (irq) begin
        done = 1;
        check(!bus_req, "R9 bus released at done", int'(bus_req), 0);
        check(prev_ack, "R9 irq right after last ack", int'(prev_ack), 1);
      end
      prev_req = bus_req; prev_ack = dev_ack;
      tick; cyc++;
    end
    check(done, "R9 block completes", int'(done), 1);
    check(words == n, "R5 word count", words, n);
    check(strobes == 2 * n, "R4 two strobe cycles per word", strobes, 2 * n);
    if (burst) check(falls == 1, "R7 bus held for burst", falls, 1);
    else       check(falls == n, "R6 bus dropped per word", falls, n);
  endtask

  initial begin
    #(20 * 150000);
    if (!finished) begin
      n_fail++; n_tests++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    check({bus_req, mem_rd, mem_wr, dev_ack, irq} == 5'b0, "R1 outputs in reset", int'({bus_req, mem_rd, mem_wr, dev_ack, irq}), 0);
    tick; rst_n = 1'b1; tick;
    check({bus_req, mem_rd, mem_wr, dev_ack, irq} == 5'b0, "R1 outputs after reset", int'({bus_req, mem_rd, mem_wr, dev_ack, irq}), 0);

    for (int i = 0; i < 6; i++) begin
      logic [17:0] v;
      v = VEC[i];
      start(v[17], v[16], v[15:4], v[3:0]);
      watch(v[15:4], int'(v[3:0]), v[17], v[16]);
    end

    // R10 and R3: stalled without grant, writes must be ignored
    grant_en = 1'b0;
    start(1'b0, 1'b1, 12'h100, 4'd4);
    tick; tick;
    for (int k = 0; k < 4; k++) begin
      check(bus_req && !mem_rd && !mem_wr, "R3 request held, no strobe without grant",
            int'({bus_req, mem_rd, mem_wr}), 4);
      tick;
    end
    wreg(2'd0, 12'h7F0);
    wreg(2'd1, 12'h001);
    wreg(2'd2, 12'h003);
    grant_en = 1'b1;
    watch(12'h100, 4, 1'b0, 1'b1);

    // R8: grant withdrawn during a burst word
    begin
      int acks = 0, lim = 0;
      start(1'b1, 1'b1, 12'h200, 4'd3);
      while (!mem_rd && lim < 20) begin tick; lim++; end
      grant_en = 1'b0;
      tick;
      check(dev_ack && mem_rd, "R8 word completes after grant drop", int'({dev_ack, mem_rd}), 3);
      tick;
      for (int k = 0; k < 4; k++) begin
        check(bus_req && !mem_rd && !dev_ack, "R8 wait for grant with request held",
              int'({bus_req, mem_rd, dev_ack}), 4);
        tick;
      end
      grant_en = 1'b1;
      lim = 0;
      while (!irq && lim < 50) begin
        if (dev_ack) begin
          check(mem_addr == 12'h201 + 12'(acks), "R8 resumed address", int'(mem_addr), int'(12'h201 + 12'(acks)));
          acks++;
        end
        tick; lim++;
      end
      check(acks == 2 && irq, "R8 remaining words after grant returns", acks, 2);
    end

    // R6: device request paused in cycle-stealing mode
    begin
      int acks = 0, lim = 0;
      dev_req = 1'b0;
      start(1'b0, 1'b0, 12'h300, 4'd3);
      for (int k = 0; k < 5; k++) begin
        check(!bus_req, "R6 no request without device request", int'(bus_req), 0);
        tick;
      end
      dev_req = 1'b1;
      while (!dev_ack && lim < 20) begin tick; lim++; end
      check(dev_ack && mem_addr == 12'h300, "R6 first word after request", int'(mem_addr), 12'h300);
      dev_req = 1'b0;
      tick;
      for (int k = 0; k < 5; k++) begin
        check(!bus_req && !dev_ack, "R6 paused with bus released", int'({bus_req, dev_ack}), 0);
        tick;
      end
      dev_req = 1'b1;
      lim = 0;
      while (!irq && lim < 50) begin
        if (dev_ack) acks++;
        tick; lim++;
      end
      check(acks == 2 && irq, "R6 remaining words after resume", acks, 2);
    end

    // R9: interrupt holds until cleared
    for (int k = 0; k < 8; k++) tick;
    check(irq, "R9 irq held", int'(irq), 1);
    wreg(2'd2, 12'h008);
    check(!irq, "R9 irq cleared by write", int'(irq), 0);

    // R11: zero count
    wreg(2'd1, 12'h000);
    wreg(2'd2, 12'h001);
    check(irq && !bus_req, "R11 zero count raises irq", int'({irq, bus_req}), 2);
    tick; tick;
    check(!bus_req && !mem_rd && !mem_wr, "R11 no bus activity", int'({bus_req, mem_rd, mem_wr}), 0);
    wreg(2'd2, 12'h008);
    check(!irq, "R9 irq cleared after zero count", int'(irq), 0);

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule